// File: doc/BRIEF.md
# UART Debug Register Bridge

This block connects an external debug host to a bank of up to 64 debug registers through one asynchronous serial line pair. Each frame carries one start bit (low), eight data bits sent least significant bit first, and one stop bit (high); this holds in both directions. The host first sends a calibration character. The bridge measures how long that character keeps the line low and sets its bit period from the result, so the host can pick any baud rate that gives at least two clock cycles per bit.

After calibration, every transaction opens with a command byte. Bit 7 selects write (1) or read (0). Bit 6 selects a single-byte access (1) or a two-byte access (0). Bits 5:0 give the register address. A write then carries one or two data bytes, low byte first, and ends in a one-cycle write strobe on the parallel register port. A read raises a one-cycle read strobe, takes the register value, and sends it back low byte first: one byte or two, as the width bit selects. The receive input passes through a synchronizer chain before any logic uses it.

Top module: `dbgu_bridge`

## Requirements
- R1: While reset is high, and right after it, `ser_out` is high and `reg_wr` and `reg_rd` are low. The bridge starts out uncalibrated.
- R2: The calibration character is 0x80. The bridge counts the clock cycles N during which the synchronized line stays low, sets the bit period to (N+4)/8 rounded down, and uses that period both to receive and to transmit. Periods of 5, 8 and 16 cycles all work.
- R3: While uncalibrated, no received traffic causes a strobe. A low pulse shorter than 12 clock cycles leaves the bridge uncalibrated.
- R4: A command with bit 7 = 1 and bit 6 = 0 is followed by a low data byte and then a high data byte. After the high byte, `reg_wr` pulses once with `reg_addr` = bits 5:0, `reg_wdata` = {high, low}, `reg_be` = 2'b11 and `reg_byte` = 0.
- R5: A command with bit 7 = 1 and bit 6 = 1 takes one data byte. It then pulses `reg_wr` with `reg_wdata` = {8'h00, byte}, `reg_be` = 2'b01 and `reg_byte` = 1.
- R6: A command with bit 7 = 0 and bit 6 = 0 pulses `reg_rd` once. The bridge samples `reg_rdata` in the cycle where `reg_rd` is high and transmits the low byte, then the high byte, as frames at the learned period. `ser_out` is high whenever no frame is being sent.
- R7: A command with bit 7 = 0 and bit 6 = 1 sends back exactly one frame, holding the low byte of the register.
- R8: A frame whose stop bit is sampled low is discarded. Any write in progress is abandoned, and the next good byte is taken as a new command.
- R9: A reset during a transaction drives `ser_out` high at once and returns the bridge to the uncalibrated state, where traffic is ignored again.
- R10: `reg_wr` and `reg_rd` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous debug reset, active high |
| ser_in | input | 1 | Serial receive line from host (asynchronous) |
| ser_out | output | 1 | Serial transmit line to host |
| reg_addr | output | ADDR_W | Register address of current access |
| reg_wdata | output | DATA_W | Write data |
| reg_be | output | DATA_W/8 | Byte enables for the write |
| reg_byte | output | 1 | Current access is single-byte |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Read data, valid while reg_rd is high |

## Verification
The bench sends low pulses of 5 and 11 cycles before calibration. A bridge that accepted too short a pulse as calibration would lock onto a wrong period and later produce stray writes. A data frame with a low stop bit is sent in the middle of a write. A design that kept the partial write would merge the next command byte into the data and strobe the wrong address. Single-byte reads are followed by a quiet window in which a second frame is caught as an error. A reset is applied partway through an outgoing frame, then calibration is repeated at a new bit period. Random writes and reads of both widths are then checked at every period.

// File: rtl/dbgu_pkg.sv
package dbgu_pkg;
   localparam int unsigned CMD_WR_BIT   = 7;
   localparam int unsigned CMD_BYTE_BIT = 6;
   localparam int unsigned CMD_ADDR_W   = 6;

   typedef enum logic [2:0] {
      RX_LEARN,
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_t;

   typedef enum logic [3:0] {
      C_CMD,
      C_WLO,
      C_WHI,
      C_RD,
      C_RCAP,
      C_SLO,
      C_WTLO,
      C_SHI,
      C_WTHI
   } ctl_state_t;
endpackage

// File: rtl/dbgu_sync.sv
module dbgu_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbgu_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgu_rx.sv
module dbgu_rx
   import dbgu_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter bit AUTO_SYNC = 1'b1,
   parameter int FIXED_DIV = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rxd,
   output logic             synced,
   output logic [CNT_W-1:0] div,
   output logic             byte_vld,
   output logic [7:0]       byte_data,
   output logic             frm_err
);
   localparam int MW = CNT_W + 3;
   localparam logic [MW-1:0] MEAS_MAX = '1;

   rx_state_t        st;
   logic             rxd_q;
   logic             lrn_act;
   logic [MW-1:0]    lrn_cnt;
   logic [MW:0]      rounded;
   logic [CNT_W:0]   period;
   logic             period_ok;
   logic [CNT_W-1:0] div_new;
   logic [CNT_W-1:0] bit_cnt;
   logic [2:0]       idx;
   logic [7:0]       shreg;
   logic             fall, rise;

   assign fall = rxd_q & ~rxd;
   assign rise = ~rxd_q & rxd;

   always_comb begin
      rounded   = {1'b0, lrn_cnt} + (MW+1)'(4);
      period    = rounded[MW:3];
      period_ok = (period >= (CNT_W+1)'(2));
   end

   generate
      if (AUTO_SYNC) begin : g_learned
         assign div_new = period[CNT_W] ? '1 : CNT_W'(period - (CNT_W+1)'(1));
      end else begin : g_fixed
         assign div_new = CNT_W'(FIXED_DIV);
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st       <= RX_LEARN;
         rxd_q    <= 1'b1;
         lrn_act  <= 1'b0;
         lrn_cnt  <= '0;
         div      <= CNT_W'(FIXED_DIV);
         bit_cnt  <= '0;
         idx      <= '0;
         shreg    <= '0;
         byte_vld <= 1'b0;
         frm_err  <= 1'b0;
      end else begin
         rxd_q    <= rxd;
         byte_vld <= 1'b0;
         frm_err  <= 1'b0;
         case (st)
            RX_LEARN: begin
               if (!lrn_act) begin
                  if (fall) begin
                     lrn_act <= 1'b1;
                     lrn_cnt <= MW'(1);
                  end
               end else if (rise) begin
                  lrn_act <= 1'b0;
                  if (period_ok) begin
                     div <= div_new;
                     st  <= RX_IDLE;
                  end
               end else if (lrn_cnt != MEAS_MAX) begin
                  lrn_cnt <= lrn_cnt + MW'(1);
               end
            end
            RX_IDLE: begin
               if (fall) begin
                  st      <= RX_START;
                  bit_cnt <= '0;
               end
            end
            RX_START: begin
               if (bit_cnt == (div >> 1)) begin
                  bit_cnt <= '0;
                  idx     <= '0;
                  st      <= rxd ? RX_IDLE : RX_DATA;
               end else begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end
            end
            RX_DATA: begin
               if (bit_cnt == div) begin
                  bit_cnt <= '0;
                  shreg   <= {rxd, shreg[7:1]};
                  if (idx == 3'd7) st <= RX_STOP;
                  else             idx <= idx + 3'd1;
               end else begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end
            end
            RX_STOP: begin
               if (bit_cnt == div) begin
                  bit_cnt <= '0;
                  if (rxd) byte_vld <= 1'b1;
                  else     frm_err  <= 1'b1;
                  st <= RX_IDLE;
               end else begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end
            end
            default: st <= RX_LEARN;
         endcase
      end
   end

   assign synced    = (st != RX_LEARN);
   assign byte_data = shreg;

   assert_quiet_unsynced_R3: assert property (@(posedge clk) disable iff (rst)
      !synced |-> (!byte_vld && !frm_err));

   assert_vld_ferr_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(byte_vld && frm_err));

   assert_div_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (synced && $past(synced)) |-> $stable(div));
endmodule

// File: rtl/dbgu_tx.sv
module dbgu_tx #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] div,
   input  logic             go,
   input  logic [7:0]       data,
   output logic             ser_out,
   output logic             busy,
   output logic             done
);
   logic [9:0]       sh;
   logic [CNT_W-1:0] bit_cnt;
   logic [3:0]       idx;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sh      <= '1;
         bit_cnt <= '0;
         idx     <= '0;
         ser_out <= 1'b1;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (go) begin
               sh      <= {1'b1, data, 1'b0};
               ser_out <= 1'b0;
               bit_cnt <= '0;
               idx     <= '0;
               busy    <= 1'b1;
            end
         end else if (bit_cnt == div) begin
            bit_cnt <= '0;
            if (idx == 4'd9) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               ser_out <= 1'b1;
            end else begin
               idx     <= idx + 4'd1;
               sh      <= {1'b1, sh[9:1]};
               ser_out <= sh[1];
            end
         end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
         end
      end
   end

   assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
      !busy |-> ser_out);

   assert_go_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      go |-> !busy);
endmodule

// File: rtl/dbgu_ctrl.sv
module dbgu_ctrl
   import dbgu_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              synced,
   input  logic              byte_vld,
   input  logic [7:0]        byte_data,
   input  logic              frm_err,
   input  logic              tx_busy,
   input  logic              tx_done,
   output logic              tx_go,
   output logic [7:0]        tx_data,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic [LANES-1:0]  reg_be,
   output logic              reg_byte,
   output logic              reg_wr,
   output logic              reg_rd
);
   ctl_state_t  st;
   logic [7:0]  lo_q;
   logic [15:0] rbuf;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st        <= C_CMD;
         lo_q      <= '0;
         rbuf      <= '0;
         tx_go     <= 1'b0;
         tx_data   <= '0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_be    <= '0;
         reg_byte  <= 1'b0;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
      end else begin
         reg_wr <= 1'b0;
         reg_rd <= 1'b0;
         tx_go  <= 1'b0;
         if (!synced) begin
            st <= C_CMD;
         end else begin
            case (st)
               C_CMD: begin
                  if (byte_vld) begin
                     reg_addr <= ADDR_W'(byte_data[CMD_ADDR_W-1:0]);
                     reg_byte <= byte_data[CMD_BYTE_BIT];
                     st       <= byte_data[CMD_WR_BIT] ? C_WLO : C_RD;
                  end
               end
               C_WLO: begin
                  if (frm_err) begin
                     st <= C_CMD;
                  end else if (byte_vld) begin
                     lo_q <= byte_data;
                     if (reg_byte) begin
                        reg_wdata <= {8'h00, byte_data};
                        reg_be    <= 2'b01;
                        reg_wr    <= 1'b1;
                        st        <= C_CMD;
                     end else begin
                        st <= C_WHI;
                     end
                  end
               end
               C_WHI: begin
                  if (frm_err) begin
                     st <= C_CMD;
                  end else if (byte_vld) begin
                     reg_wdata <= {byte_data, lo_q};
                     reg_be    <= 2'b11;
                     reg_wr    <= 1'b1;
                     st        <= C_CMD;
                  end
               end
               C_RD: begin
                  reg_rd <= 1'b1;
                  st     <= C_RCAP;
               end
               C_RCAP: begin
                  rbuf <= reg_byte ? {8'h00, reg_rdata[7:0]} : reg_rdata;
                  st   <= C_SLO;
               end
               C_SLO: begin
                  if (!tx_busy) begin
                     tx_go   <= 1'b1;
                     tx_data <= rbuf[7:0];
                     st      <= C_WTLO;
                  end
               end
               C_WTLO: begin
                  if (tx_done) st <= reg_byte ? C_CMD : C_SHI;
               end
               C_SHI: begin
                  if (!tx_busy) begin
                     tx_go   <= 1'b1;
                     tx_data <= rbuf[15:8];
                     st      <= C_WTHI;
                  end
               end
               C_WTHI: begin
                  if (tx_done) st <= C_CMD;
               end
               default: st <= C_CMD;
            endcase
         end
      end
   end

   assert_wr_rd_excl_R10: assert property (@(posedge clk) disable iff (rst)
      !(reg_wr && reg_rd));

   assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      reg_wr |=> !reg_wr);

   assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      reg_rd |=> !reg_rd);

   assert_byte_lane_R5: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_byte) |-> (reg_be == 2'b01 && reg_wdata[15:8] == 8'h00));

   assert_word_lane_R4: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && !reg_byte) |-> (reg_be == 2'b11));
endmodule

// File: rtl/dbgu_bridge.sv
module dbgu_bridge #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit AUTO_SYNC   = 1'b1,
   parameter int FIXED_DIV   = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ser_in,
   output logic                ser_out,
   output logic [ADDR_W-1:0]   reg_addr,
   output logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W/8-1:0] reg_be,
   output logic                reg_byte,
   output logic                reg_wr,
   output logic                reg_rd,
   input  logic [DATA_W-1:0]   reg_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr
         $error("dbgu_bridge: ADDR_W must be 1..6");
      end
      if (DATA_W != 16) begin : g_bad_data
         $error("dbgu_bridge: DATA_W must be 16");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("dbgu_bridge: CNT_W must be at least 4");
      end
      if (FIXED_DIV < 1 || FIXED_DIV >= (1 << CNT_W)) begin : g_bad_div
         $error("dbgu_bridge: FIXED_DIV out of range");
      end
   endgenerate

   logic             rxd_s;
   logic             synced;
   logic [CNT_W-1:0] div;
   logic             byte_vld;
   logic [7:0]       byte_data;
   logic             frm_err;
   logic             tx_go, tx_busy, tx_done;
   logic [7:0]       tx_data;

   dbgu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(ser_in), .q(rxd_s)
   );

   dbgu_rx #(.CNT_W(CNT_W), .AUTO_SYNC(AUTO_SYNC), .FIXED_DIV(FIXED_DIV)) u_rx (
      .clk(clk), .rst(rst), .rxd(rxd_s), .synced(synced), .div(div),
      .byte_vld(byte_vld), .byte_data(byte_data), .frm_err(frm_err)
   );

   dbgu_tx #(.CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst(rst), .div(div), .go(tx_go), .data(tx_data),
      .ser_out(ser_out), .busy(tx_busy), .done(tx_done)
   );

   dbgu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst(rst), .synced(synced), .byte_vld(byte_vld),
      .byte_data(byte_data), .frm_err(frm_err), .tx_busy(tx_busy),
      .tx_done(tx_done), .tx_go(tx_go), .tx_data(tx_data),
      .reg_rdata(reg_rdata), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_be(reg_be), .reg_byte(reg_byte), .reg_wr(reg_wr), .reg_rd(reg_rd)
   );

   assert_strobe_needs_sync_R3: assert property (@(posedge clk) disable iff (rst)
      (reg_wr || reg_rd) |-> synced);
endmodule

// File: tb/tb_dbgu_bridge.sv
module tb_dbgu_bridge;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              ser_in = 1'b1;
   logic              ser_out;
   logic [ADDR_W-1:0] reg_addr;
   logic [DATA_W-1:0] reg_wdata;
   logic [1:0]        reg_be;
   logic              reg_byte, reg_wr, reg_rd;
   logic [DATA_W-1:0] reg_rdata;

   always #2 clk = ~clk;

   dbgu_bridge dut (
      .clk(clk), .rst(rst), .ser_in(ser_in), .ser_out(ser_out),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
      .reg_byte(reg_byte), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] regs [64];
   int          wr_cnt, rd_cnt;
   logic [5:0]  last_addr;
   logic [15:0] last_wdata;
   logic [1:0]  last_be;
   logic        last_byte;

   function automatic logic [15:0] f_init(int i);
      return 16'(i * 16'h0931) ^ 16'hC35A;
   endfunction

   function automatic logic [7:0] f_cmd(logic w, logic b, logic [5:0] a);
      return {w, b, a};
   endfunction

   function automatic logic [15:0] f_wdata(logic b, logic [15:0] d);
      return b ? {8'h00, d[7:0]} : d;
   endfunction

   function automatic logic [1:0] f_be(logic b);
      return b ? 2'b01 : 2'b11;
   endfunction

   assign reg_rdata = regs[reg_addr];

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 64; i++) regs[i] <= f_init(i);
         wr_cnt <= 0;
         rd_cnt <= 0;
      end else begin
         if (reg_wr) begin
            wr_cnt     <= wr_cnt + 1;
            last_addr  <= reg_addr;
            last_wdata <= reg_wdata;
            last_be    <= reg_be;
            last_byte  <= reg_byte;
            if (reg_be[0]) regs[reg_addr][7:0]  <= reg_wdata[7:0];
            if (reg_be[1]) regs[reg_addr][15:8] <= reg_wdata[15:8];
         end
         if (reg_rd) rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_frame(int p, logic [7:0] b, logic stop);
      for (int i = 0; i < 10; i++) begin
         ser_in = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
         repeat (p) @(negedge clk);
      end
      ser_in = 1'b1;
   endtask

   task automatic rx_byte(int p, output logic [7:0] b, output logic ok);
      int t;
      t  = 0;
      ok = 1'b1;
      b  = 8'h00;
      while (ser_out !== 1'b0) begin
         @(negedge clk);
         t++;
         if (t > 60 * p) begin
            ok = 1'b0;
            return;
         end
      end
      repeat (p / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (p) @(negedge clk);
         b[i] = ser_out;
      end
      repeat (p) @(negedge clk);
      if (ser_out !== 1'b1) ok = 1'b0;
   endtask

   task automatic quiet_line(int cycles, string req);
      int lows;
      lows = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (ser_out !== 1'b1) lows++;
      end
      chk(req, lows, 0);
   endtask

   task automatic calibrate(int p);
      send_frame(p, 8'h80, 1'b1);
      repeat (3 * p) @(negedge clk);
   endtask

   task automatic do_write(int p, logic b, logic [5:0] a, logic [15:0] d);
      int pre;
      string tag;
      tag = b ? "R5" : "R4";
      pre = wr_cnt;
      send_frame(p, f_cmd(1'b1, b, a), 1'b1);
      send_frame(p, d[7:0], 1'b1);
      if (!b) send_frame(p, d[15:8], 1'b1);
      repeat (2 * p) @(negedge clk);
      chk({tag, " write count"}, wr_cnt, pre + 1);
      chk({tag, " address"}, last_addr, a);
      chk({tag, " data"}, last_wdata, f_wdata(b, d));
      chk({tag, " byte enables"}, last_be, f_be(b));
      chk({tag, " width flag"}, last_byte, b);
   endtask

   task automatic do_read(int p, logic b, logic [5:0] a);
      logic [15:0] exp;
      logic [7:0]  lo, hi;
      logic        ok_lo, ok_hi;
      int          pre;
      exp   = regs[a];
      pre   = rd_cnt;
      hi    = 8'h00;
      ok_hi = 1'b1;
      fork
         send_frame(p, f_cmd(1'b0, b, a), 1'b1);
         begin
            rx_byte(p, lo, ok_lo);
            if (!b) rx_byte(p, hi, ok_hi);
         end
      join
      if (b) begin
         chk("R7 frame received", ok_lo, 1'b1);
         chk("R7 low byte", lo, exp[7:0]);
         quiet_line(12 * p, "R7 no second frame");
      end else begin
         chk("R6 frames received", {ok_lo, ok_hi}, 2'b11);
         chk("R6 read data", {hi, lo}, exp);
         repeat (p) @(negedge clk);
      end
      chk("R10 one read strobe", rd_cnt, pre + 1);
   endtask

   task automatic do_random(int p, int n);
      for (int k = 0; k < n; k++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[0]) do_write(p, r[1], r[7:2], r[23:8]);
         else      do_read(p, r[1], r[7:2]);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst    = 1'b1;
      ser_in = 1'b1;
      @(negedge clk);
      chk("R9 line high in reset", ser_out, 1'b1);
      repeat (3) @(negedge clk);
      chk("R1 line idle", ser_out, 1'b1);
      chk("R1 no strobes", {reg_wr, reg_rd}, 2'b00);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 line idle after release", ser_out, 1'b1);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int pre;
      void'($urandom(32'h5EED1234));
      apply_reset();

      // R3: traffic and short pulses before calibration
      pre = wr_cnt;
      send_frame(5, 8'hFF, 1'b1);
      send_frame(5, 8'hFF, 1'b1);
      send_frame(11, 8'hFF, 1'b1);
      send_frame(11, 8'hFF, 1'b1);
      repeat (20) @(negedge clk);
      chk("R3 no write while uncalibrated", wr_cnt, pre);
      quiet_line(40, "R3 line idle while uncalibrated");

      // R2: calibrate at 5 cycles per bit
      calibrate(5);
      do_write(5, 1'b0, 6'd5, 16'hA55A);
      do_write(5, 1'b1, 6'd63, 16'h7E3C);
      do_read(5, 1'b0, 6'd5);
      do_read(5, 1'b1, 6'd63);
      do_read(5, 1'b0, 6'd0);

      // R8: framing error abandons the write
      pre = wr_cnt;
      send_frame(5, f_cmd(1'b1, 1'b0, 6'd9), 1'b1);
      send_frame(5, 8'h11, 1'b0);
      repeat (10) @(negedge clk);
      send_frame(5, f_cmd(1'b1, 1'b0, 6'd10), 1'b1);
      send_frame(5, 8'hEF, 1'b1);
      send_frame(5, 8'hBE, 1'b1);
      repeat (10) @(negedge clk);
      chk("R8 one write after error", wr_cnt, pre + 1);
      chk("R8 address of new command", last_addr, 6'd10);
      chk("R8 data of new command", last_wdata, 16'hBEEF);

      do_random(5, 24);

      // R9: reset in the middle of a response
      send_frame(5, f_cmd(1'b0, 1'b0, 6'd3), 1'b1);
      begin
         int t;
         t = 0;
         while (ser_out !== 1'b0 && t < 200) begin
            @(negedge clk);
            t++;
         end
         chk("R9 response started", ser_out, 1'b0);
      end
      repeat (15) @(negedge clk);
      apply_reset();
      quiet_line(100, "R9 line stays idle");
      pre = wr_cnt;
      send_frame(5, 8'hFF, 1'b1);
      send_frame(5, 8'hFF, 1'b1);
      repeat (20) @(negedge clk);
      chk("R9 uncalibrated after reset", wr_cnt, pre);

      // R2: other periods
      calibrate(8);
      do_write(8, 1'b0, 6'd33, 16'h1234);
      do_read(8, 1'b0, 6'd33);
      do_random(8, 12);

      apply_reset();
      calibrate(16);
      do_write(16, 1'b1, 6'd1, 16'h00C7);
      do_read(16, 1'b0, 6'd1);
      do_random(16, 6);

      summary();
      $finish;
   end
endmodule